// File: doc/BRIEF.md
# Secondary Core Release Controller

This block is a small memory-mapped register file that a boot processor uses to start the other cores of a multi-core cluster. Each core owns one 32-byte slot. The slot holds a 64-bit start address, a 64-bit first-argument value and a 32-bit processor identifier, plus reserved words. Firmware running on the boot core fills in a slot with narrow big-endian stores. The target core stays parked until the start address becomes even.

Every accepted store is checked against the updated slot. When bit 0 of the slot's start address is zero, the block issues a one-cycle release pulse naming that core. With the pulse it presents the core's boot parameters:

- the program counter, which is the address offset inside a 64 MiB window;
- the window's base, which is the address with its low 26 bits cleared;
- the window size;
- the first-argument value.

The block also replaces the slot's identifier field with the released core's own hardware identifier. Slot 0 belongs to the boot core and never accepts stores. Slots of cores that are not present also never accept stores.

Top module: `spin_release_ctrl`

## Requirements
- R1: After reset, slot i reads back a start address of 1, a first-argument value of i and a processor identifier of i. Every other byte reads back 0. The start address is bytes 0..7 of the slot, the argument is bytes 8..15 and the identifier is bytes 20..23, each stored most significant byte first.
- R2: Byte address A selects slot A/32 and byte A%32 within that slot. Slot byte o always holds the more significant part of a field than slot byte o+1 (big-endian).
- R3: A store of `busSize` = 1, 2 or 4 bytes updates exactly the bytes o..o+size-1 of the slot. The least significant size*8 bits of `busWdata` are used, and the most significant of those bytes lands at o. All other bytes of the slot keep their values.
- R4: A store whose size is not 1, 2 or 4 is ignored. A store whose offset is not a multiple of its size is also ignored. An ignored store changes no slot and raises no release.
- R5: Stores to slot 0 are ignored.
- R6: Stores to a slot whose `corePresent` bit is 0 are ignored.
- R7: On the clock edge that accepts a store, `relValid` goes high for exactly one cycle if the updated start address has bit 0 clear. It stays low if bit 0 is set. `relCore` gives the slot number.
- R8: While `relValid` is high, `relPc` is the start address ANDed with 2^26−1, and `relMapBase` is the start address with those 26 bits cleared.
- R9: While `relValid` is high, `relArg` is the slot's 64-bit first-argument value. `relMapSize` always reads 2^26 (64 MiB).
- R10: A store that raises a release also writes the released core's `corePid` word into slot bytes 20..23. This overrides any data the store itself put there.
- R11: Every load gets a response one cycle later: `rdValid` is high and `rdErr` is set. `rdErr` is 1 if the size is not 1, 2 or 4, if the offset is not a multiple of the size, or if the slot number is out of range. Otherwise `rdErr` is 0.
- R12: A successful load of n bytes at offset o returns bytes o..o+n−1 in the least significant n*8 bits of `rdData`, with byte o most significant. The upper bits are zero. A failed load returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| corePresent | input | NUM_CORES | One bit per core; 1 lets that core's slot accept stores |
| corePid | input | 32*NUM_CORES | Hardware identifier of each core, core i at bits 32i+31..32i |
| busValid | input | 1 | Access request this cycle |
| busWrite | input | 1 | 1 = store, 0 = load |
| busAddr | input | IDX_W+5 | Byte address within the region |
| busSize | input | 3 | Access width in bytes |
| busWdata | input | 32 | Store data, right-aligned |
| rdValid | output | 1 | Load response valid, one cycle after the request |
| rdData | output | 32 | Load data, right-aligned |
| rdErr | output | 1 | Load error response |
| relValid | output | 1 | One-cycle release pulse |
| relCore | output | IDX_W | Index of the released core |
| relPc | output | 64 | Start program counter |
| relMapBase | output | 64 | Base of the initial 64 MiB mapping |
| relMapSize | output | 64 | Size of the initial mapping |
| relArg | output | 64 | First-argument register value |

## Verification
The bench builds the block with NUM_CORES = 4 and the default 26-bit window, and marks core 2 absent. This keeps the whole 128-byte region small enough to sweep. Every slot, every legal and illegal size, and every aligned offset is exercised, so stores to the boot slot, to an absent core, to the identifier field and to reserved bytes are all covered. Each store is compared against a byte-level model in the bench. That model predicts the release pulse, the address split and the identifier overwrite arithmetically.

// File: rtl/spin_release_pkg.sv
package spin_release_pkg;

  localparam int SLOT_BYTES = 32;
  localparam int OFF_W      = 5;
  localparam int START_LO   = 0;
  localparam int ARG_LO     = 8;
  localparam int PID_LO     = 20;

  typedef logic [SLOT_BYTES-1:0][7:0] slot_t;

  typedef struct packed {
    logic             wrEn;
    logic             rdEn;
    logic             rdErr;
    logic [OFF_W-1:0] offset;
    logic [2:0]       nBytes;
  } strobe_t;

endpackage

// File: rtl/spin_ctrl_decode.sv
module spin_ctrl_decode
  import spin_release_pkg::*;
#(
  parameter int NUM_CORES = 32,
  parameter int IDX_W     = 5,
  localparam int ADDR_W   = IDX_W + OFF_W
) (
  input  logic                 busValid,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [2:0]           busSize,
  input  logic [NUM_CORES-1:0] corePresent,
  output strobe_t              strb,
  output logic [IDX_W-1:0]     entrySel
);

  logic             sizeOk;
  logic             aligned;
  logic             inRange;
  logic             writable;
  logic [OFF_W-1:0] offset;
  logic [OFF_W-1:0] lowMask;

  always_comb begin
    entrySel = busAddr[ADDR_W-1:OFF_W];
    offset   = busAddr[OFF_W-1:0];
    sizeOk   = (busSize == 3'd1) || (busSize == 3'd2) || (busSize == 3'd4);
    lowMask  = OFF_W'(busSize) - OFF_W'(1);
    aligned  = (offset & lowMask) == '0;
    inRange  = 32'(entrySel) < NUM_CORES;
    writable = inRange && (entrySel != '0) && corePresent[entrySel];

    strb.wrEn   = busValid && busWrite && sizeOk && aligned && writable;
    strb.rdEn   = busValid && !busWrite;
    strb.rdErr  = !(sizeOk && aligned && inRange);
    strb.offset = offset;
    strb.nBytes = busSize;
  end

endmodule

// File: rtl/spin_entry_datapath.sv
module spin_entry_datapath
  import spin_release_pkg::*;
#(
  parameter int NUM_CORES = 32,
  parameter int IDX_W     = 5,
  parameter int MAP_SHIFT = 26
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 strb,
  input  logic [IDX_W-1:0]        entrySel,
  input  logic [31:0]             busWdata,
  input  logic [32*NUM_CORES-1:0] corePid,
  output logic                    rdValid,
  output logic [31:0]             rdData,
  output logic                    rdErr,
  output logic                    relValid,
  output logic [IDX_W-1:0]        relCore,
  output logic [63:0]             relPc,
  output logic [63:0]             relMapBase,
  output logic [63:0]             relArg
);

  localparam logic [63:0] OFFSET_MASK = (64'd1 << MAP_SHIFT) - 64'd1;

  slot_t            slots [NUM_CORES];
  slot_t            cur;
  slot_t            merged;
  logic [63:0]      startVal;
  logic [63:0]      argVal;
  logic [31:0]      pidWord;
  logic [31:0]      readWord;
  logic             relHit;
  logic [IDX_W-1:0] selSafe;
  int               nEff;

  function automatic slot_t resetSlot(int idx);
    slot_t s;
    logic [63:0] v;
    s = '0;
    v = 64'(idx);
    s[START_LO+7] = 8'h01;
    for (int b = 0; b < 8; b++) s[ARG_LO+b] = v[63-8*b -: 8];
    for (int b = 0; b < 4; b++) s[PID_LO+b] = v[31-8*b -: 8];
    return s;
  endfunction

  always_comb begin
    selSafe  = (32'(entrySel) < NUM_CORES) ? entrySel : '0;
    nEff     = (int'(strb.nBytes) > 4) ? 4 : int'(strb.nBytes);
    cur      = slots[selSafe];
    merged   = cur;
    readWord = '0;
    pidWord  = corePid[32*selSafe +: 32];
    for (int k = 0; k < 4; k++) begin
      if (k < nEff) begin
        merged[strb.offset + OFF_W'(k)] = busWdata[8*(nEff-1-k) +: 8];
        readWord[8*(nEff-1-k) +: 8]     = cur[strb.offset + OFF_W'(k)];
      end
    end
    for (int b = 0; b < 8; b++) begin
      startVal[63-8*b -: 8] = merged[START_LO+b];
      argVal[63-8*b -: 8]   = merged[ARG_LO+b];
    end
    relHit = strb.wrEn && !startVal[0];
    if (relHit) begin
      for (int b = 0; b < 4; b++) merged[PID_LO+b] = pidWord[31-8*b -: 8];
    end
  end

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slots[g] <= resetSlot(g);
      end else if (strb.wrEn && (32'(selSafe) == g)) begin
        slots[g] <= merged;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdErr   <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strb.rdEn;
      rdErr   <= strb.rdEn && strb.rdErr;
      rdData  <= (strb.rdEn && !strb.rdErr) ? readWord : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      relValid   <= 1'b0;
      relCore    <= '0;
      relPc      <= '0;
      relMapBase <= '0;
      relArg     <= '0;
    end else begin
      relValid <= relHit;
      if (relHit) begin
        relCore    <= selSafe;
        relPc      <= startVal & OFFSET_MASK;
        relMapBase <= startVal & ~OFFSET_MASK;
        relArg     <= argVal;
      end
    end
  end

endmodule

// File: rtl/spin_release_ctrl.sv
module spin_release_ctrl
  import spin_release_pkg::*;
#(
  parameter int NUM_CORES = 32,
  parameter int MAP_SHIFT = 26,
  localparam int IDX_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int ADDR_W   = IDX_W + OFF_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_CORES-1:0]    corePresent,
  input  logic [32*NUM_CORES-1:0] corePid,
  input  logic                    busValid,
  input  logic                    busWrite,
  input  logic [ADDR_W-1:0]       busAddr,
  input  logic [2:0]              busSize,
  input  logic [31:0]             busWdata,
  output logic                    rdValid,
  output logic [31:0]             rdData,
  output logic                    rdErr,
  output logic                    relValid,
  output logic [IDX_W-1:0]        relCore,
  output logic [63:0]             relPc,
  output logic [63:0]             relMapBase,
  output logic [63:0]             relMapSize,
  output logic [63:0]             relArg
);

  strobe_t          strb;
  logic [IDX_W-1:0] entrySel;

  assign relMapSize = 64'd1 << MAP_SHIFT;

  spin_ctrl_decode #(
    .NUM_CORES (NUM_CORES),
    .IDX_W     (IDX_W)
  ) u_decode (
    .busValid    (busValid),
    .busWrite    (busWrite),
    .busAddr     (busAddr),
    .busSize     (busSize),
    .corePresent (corePresent),
    .strb        (strb),
    .entrySel    (entrySel)
  );

  spin_entry_datapath #(
    .NUM_CORES (NUM_CORES),
    .IDX_W     (IDX_W),
    .MAP_SHIFT (MAP_SHIFT)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .entrySel   (entrySel),
    .busWdata   (busWdata),
    .corePid    (corePid),
    .rdValid    (rdValid),
    .rdData     (rdData),
    .rdErr      (rdErr),
    .relValid   (relValid),
    .relCore    (relCore),
    .relPc      (relPc),
    .relMapBase (relMapBase),
    .relArg     (relArg)
  );

endmodule

// File: rtl/spin_release_chk.sv
module spin_release_chk #(
  parameter int NUM_CORES = 32,
  parameter int IDX_W     = 5,
  parameter int ADDR_W    = 10
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_CORES-1:0] corePresent,
  input logic                 busValid,
  input logic                 busWrite,
  input logic [ADDR_W-1:0]    busAddr,
  input logic [2:0]           busSize,
  input logic                 rdValid,
  input logic                 rdErr,
  input logic                 relValid,
  input logic [IDX_W-1:0]     relCore,
  input logic [63:0]          relPc
);

  logic [NUM_CORES-1:0] presPrev;
  logic                 sizeLegal;

  assign sizeLegal = (busSize == 3'd1) || (busSize == 3'd2) || (busSize == 3'd4);

  always_ff @(posedge clk) begin
    if (!rstN) presPrev <= '0;
    else       presPrev <= corePresent;
  end

  a_r7_release_after_store: assert property (@(posedge clk) disable iff (!rstN)
    relValid |-> $past(busValid && busWrite));

  a_r5_never_primary: assert property (@(posedge clk) disable iff (!rstN)
    relValid |-> (relCore != '0));

  a_r6_release_present: assert property (@(posedge clk) disable iff (!rstN)
    relValid |-> presPrev[relCore]);

  a_r8_pc_even: assert property (@(posedge clk) disable iff (!rstN)
    relValid |-> !relPc[0]);

  a_r4_bad_size_no_release: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && !sizeLegal) |=> !relValid);

  a_r11_load_response: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(busValid && !busWrite));

  a_r11_bad_size_error: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite && !sizeLegal) |=> (rdValid && rdErr));

endmodule

bind spin_release_ctrl spin_release_chk #(
  .NUM_CORES (NUM_CORES),
  .IDX_W     (IDX_W),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .corePresent (corePresent),
  .busValid    (busValid),
  .busWrite    (busWrite),
  .busAddr     (busAddr),
  .busSize     (busSize),
  .rdValid     (rdValid),
  .rdErr       (rdErr),
  .relValid    (relValid),
  .relCore     (relCore),
  .relPc       (relPc)
);

// File: tb/spin_release_ctrl_tb.sv
module spin_release_ctrl_tb;

  localparam int NC   = 4;
  localparam int IW   = 2;
  localparam int AW   = IW + 5;
  localparam int MSH  = 26;
  localparam logic [63:0] MASK = (64'd1 << MSH) - 64'd1;

  logic          clk = 1'b0;
  logic          rstN;
  logic [NC-1:0] corePresent;
  logic [32*NC-1:0] corePid;
  logic          busValid, busWrite;
  logic [AW-1:0] busAddr;
  logic [2:0]    busSize;
  logic [31:0]   busWdata;
  logic          rdValid, rdErr, relValid;
  logic [31:0]   rdData;
  logic [IW-1:0] relCore;
  logic [63:0]   relPc, relMapBase, relMapSize, relArg;

  logic [7:0] model [NC][32];
  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  spin_release_ctrl #(.NUM_CORES(NC), .MAP_SHIFT(MSH)) u_dut (
    .clk(clk), .rstN(rstN), .corePresent(corePresent), .corePid(corePid),
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busSize(busSize), .busWdata(busWdata), .rdValid(rdValid),
    .rdData(rdData), .rdErr(rdErr), .relValid(relValid), .relCore(relCore),
    .relPc(relPc), .relMapBase(relMapBase), .relMapSize(relMapSize),
    .relArg(relArg)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] getQ(int e, int base);
    logic [63:0] v;
    for (int b = 0; b < 8; b++) v[63-8*b -: 8] = model[e][base+b];
    return v;
  endfunction

  function automatic logic [31:0] pidOf(int e);
    return 32'hC0DE_0000 + 32'(e) * 32'h0000_1111;
  endfunction

  task automatic modelReset();
    for (int e = 0; e < NC; e++) begin
      for (int b = 0; b < 32; b++) model[e][b] = 8'h00;
      model[e][7] = 8'h01;
      model[e][15] = 8'(e);
      model[e][23] = 8'(e);
    end
  endtask

  task automatic doRead(int e, int off, int sz, string req);
    bit legal;
    logic [31:0] exp;
    legal = (sz == 1 || sz == 2 || sz == 4) && (off % sz == 0) && (e < NC);
    exp = '0;
    if (legal) for (int k = 0; k < sz; k++) exp[8*(sz-1-k) +: 8] = model[e][off+k];
    @(negedge clk);
    busValid = 1; busWrite = 0; busAddr = AW'(e*32 + off); busSize = 3'(sz);
    @(negedge clk);
    busValid = 0;
    check({req, " R11 rdValid"}, 64'(rdValid), 64'd1);
    check({req, " R11 rdErr"}, 64'(rdErr), 64'(!legal));
    check({req, " R12 rdData"}, 64'(rdData), 64'(exp));
  endtask

  task automatic doWrite(int e, int off, int sz, logic [31:0] v, string req);
    bit acc, rel;
    logic [63:0] sa;
    acc = (sz == 1 || sz == 2 || sz == 4) && (off % sz == 0) && e != 0 && corePresent[e];
    rel = 0;
    if (acc) begin
      for (int k = 0; k < sz; k++) model[e][off+k] = v[8*(sz-1-k) +: 8];
      sa = getQ(e, 0);
      rel = !sa[0];
      if (rel) for (int b = 0; b < 4; b++) model[e][20+b] = pidOf(e) >> (24 - 8*b);
    end
    @(negedge clk);
    busValid = 1; busWrite = 1; busAddr = AW'(e*32 + off); busSize = 3'(sz); busWdata = v;
    @(negedge clk);
    busValid = 0;
    check({req, " R7 relValid"}, 64'(relValid), 64'(rel));
    if (rel) begin
      check("R7 relCore", 64'(relCore), 64'(e));
      check("R8 relPc", relPc, sa & MASK);
      check("R8 relMapBase", relMapBase, sa & ~MASK);
      check("R9 relArg", relArg, getQ(e, 8));
      check("R9 relMapSize", relMapSize, 64'h0400_0000);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog R7 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rstN = 0; busValid = 0; busWrite = 0; busAddr = '0; busSize = 3'd4; busWdata = '0;
    corePresent = 4'b1011;
    for (int e = 0; e < NC; e++) corePid[32*e +: 32] = pidOf(e);
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1 reset contents, word reads over whole region
    for (int e = 0; e < NC; e++)
      for (int off = 0; off < 32; off += 4) doRead(e, off, 4, "R1");
    check("R7 relValid idle after reset", 64'(relValid), 64'd0);

    // R2 / R12 narrow reads at every aligned offset
    for (int off = 0; off < 32; off++) doRead(1, off, 1, "R2");
    for (int off = 0; off < 32; off += 2) doRead(3, off, 2, "R12");

    // R11 illegal sizes and misaligned loads
    for (int sz = 0; sz < 8; sz++) doRead(2, 4, sz, "R11");
    doRead(1, 2, 4, "R11");
    doRead(1, 1, 2, "R11");

    // R5 primary slot, R6 absent core
    doWrite(0, 4, 4, 32'h0000_0000, "R5");
    doRead(0, 4, 4, "R5");
    doWrite(2, 4, 4, 32'h1234_5670, "R6");
    doRead(2, 4, 4, "R6");

    // R3 bytewise argument, then release with address split
    for (int b = 0; b < 8; b++) doWrite(1, 8 + b, 1, 32'(8'h11 * (b + 1)), "R3");
    doRead(1, 8, 4, "R3");
    doRead(1, 12, 4, "R3");
    doWrite(1, 0, 4, 32'h0000_0001, "R3");
    doWrite(1, 4, 4, 32'h0A12_3458, "R7");
    check("R8 relPc value", relPc, 64'h0000_0000_0212_3458);
    check("R8 relMapBase value", relMapBase, 64'h0000_0001_0800_0000);
    check("R9 relArg value", relArg, 64'h1122_3344_5566_7788);
    @(negedge clk);
    check("R7 single pulse", 64'(relValid), 64'd0);
    doRead(1, 20, 4, "R10");

    // R4 ignored stores
    doWrite(3, 2, 4, 32'hFFFF_FFFE, "R4");
    doWrite(3, 4, 3, 32'h0000_0000, "R4");
    doWrite(3, 4, 0, 32'h0000_0000, "R4");
    doRead(3, 4, 4, "R4");

    // R3 halfword release on slot 3
    doWrite(3, 6, 2, 32'h0000_0000, "R3");

    // R10 store into the identifier field of an already even address
    doWrite(3, 20, 4, 32'hDEAD_BEEF, "R10");
    doRead(3, 20, 4, "R10");

    // sweep every slot, size and aligned offset
    for (int e = 0; e < NC; e++)
      for (int s = 0; s < 3; s++) begin
        int sz;
        sz = 1 << s;
        for (int off = 0; off < 32; off += sz)
          doWrite(e, off, sz, 32'h9E37_79B9 * 32'(e * 97 + off * 5 + sz), "R3");
      end

    for (int e = 0; e < NC; e++)
      for (int off = 0; off < 32; off += 4) doRead(e, off, 4, "R2");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule